// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a single-cycle synchronous SRAM. It holds a small word array, four byte lanes wide, and each lane carries a ninth bit for parity. All control inputs are sampled on the rising clock edge, and only on edges where the clock enable is low. An access starts on a load edge with a full address. After that, the access can continue as a four-beat burst. A 2-bit counter steps the two low address bits, and the burst order is set by a strap input. The upper address bits do not change during a burst.

Reads are registered. After the edge that presents the address, the word appears on `dout`. Writes use a late-data scheme: the address and byte-lane enables are taken on one edge, and the data is taken on the next qualified edge. The data bus is split into `din`, `dout` and a drive-enable `dout_en`. The drive enable combines the registered read-valid state with an asynchronous active-low output enable and a sleep input. The bus has no valid/ready handshake. The cycle-exact protocol of a synchronous memory takes the place of back-pressure, and `cken_n` is the only way to stall it.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, `dout_en` is 0 and `dout` is 0. No access is pending after reset.
- R2: A qualified edge with `adv_ld`=0, the device selected and `wr_n`=1 starts a read. Just after that edge, `dout` holds the word at the sampled address, and `dout_en` is 1 if `oe_n`=0 and `sleep`=0.
- R3: A qualified write load edge (`wr_n`=0) samples the address and `byte_wr_n`. The next qualified edge stores `din` into lane i (bits 9i+8..9i, with bit 9i+8 as the parity bit) only where `byte_wr_n[i]`=0. The other lanes keep their old contents.
- R4: With `burst_interleave`=0, beat n of a burst uses the low address bits (start+n) mod 4. Beat n is the n-th qualified edge with `adv_ld`=1. The upper address bits stay those of the load.
- R5: With `burst_interleave`=1, beat n uses the low address bits start XOR n. For a start of 1 this gives the order 1,0,3,2.
- R6: On an edge with `cken_n`=1, no register changes. `dout` and the burst position are both held, so the next beat continues from the same place.
- R7: The device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load edge with any other combination deselects the device, and `dout_en` is 0 in the following cycle.
- R8: An advance edge (`adv_ld`=1) while the device is deselected keeps it deselected, and `dout_en` stays 0.
- R9: In the cycle after a write load or a write beat, `dout_en` is 0 whatever `oe_n` is.
- R10: `oe_n`=1 drives `dout_en` to 0 at once, with no clock edge needed.
- R11: While `sleep`=1, load edges start no access, `dout_en` is 0, and the array contents are preserved.
- R12: A read whose address matches the write completing on the same edge returns the new data in the enabled lanes and the old data in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cken_n | input | 1 | Clock enable, active low; when high the edge is ignored |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write request on a load edge, active low |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| byte_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| burst_interleave | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| din | input | DATA_W | Write data, lane i at bits 9i+8..9i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The hardest state to reach from the ports is a read that lands on the very edge that completes a partial write to the same word. To get there, the bench loads a write with two lanes masked and follows it at once with a read load of that address, with the new data on `din`. It then reads the word again to confirm what the array stored. A second hard case is a clock-enable stall in the middle of a read burst. The bench wraps a linear burst past the end of its four-word group and checks that the beat after the stall continues from the held position, not one step past it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Low address bits for a burst beat: XOR for interleaved order, sum for linear.
  function automatic logic [CNT_W-1:0] burst_step(input logic [CNT_W-1:0] start,
                                                  input logic [CNT_W-1:0] off,
                                                  input logic interleave);
    return interleave ? (start ^ off) : (start + off);
  endfunction
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n,
  input  logic              selected,
  input  logic              sleep,
  input  logic              wr_n,
  input  logic              adv_ld,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic              rd_valid
);
  acc_kind_t         kind_q, kind_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  off_q, off_d;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [LANES-1:0]  pend_lanes_q;
  logic              rd_valid_q;

  always_comb begin
    kind_d   = kind_q;
    base_d   = base_q;
    off_d    = off_q;
    acc_addr = base_q;
    if (!adv_ld) begin
      base_d   = addr;
      off_d    = '0;
      acc_addr = addr;
      if (selected && !sleep) kind_d = wr_n ? ACC_READ : ACC_WRITE;
      else                    kind_d = ACC_IDLE;
    end else begin
      off_d    = off_q + 1'b1;
      acc_addr = {base_q[ADDR_W-1:CNT_W],
                  burst_step(base_q[CNT_W-1:0], off_d, interleave)};
      if (sleep) kind_d = ACC_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q       <= ACC_IDLE;
      base_q       <= '0;
      off_q        <= '0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      pend_lanes_q <= '0;
      rd_valid_q   <= 1'b0;
    end else if (!cken_n) begin
      kind_q       <= kind_d;
      base_q       <= base_d;
      off_q        <= off_d;
      pend_q       <= (kind_d == ACC_WRITE);
      pend_addr_q  <= acc_addr;
      pend_lanes_q <= ~byte_wr_n;
      rd_valid_q   <= (kind_d == ACC_READ);
    end
  end

  assign rd_fire  = !cken_n && (kind_d == ACC_READ);
  assign wr_fire  = !cken_n && pend_q;
  assign wr_addr  = pend_addr_q;
  assign wr_lanes = pend_lanes_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_fire,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_fire,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] word;
    logic              hit;

    assign hit  = wr_fire && wr_lanes[g] && (wr_addr == rd_addr);
    assign word = hit ? wr_data[g*LANE_W +: LANE_W] : mem[rd_addr];

    always_ff @(posedge clk) begin
      if (wr_fire && wr_lanes[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data[g*LANE_W +: LANE_W] <= '0;
      else if (rd_fire) rd_data[g*LANE_W +: LANE_W] <= word;
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              wr_n,
  input  logic              adv_ld,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_interleave,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              selected;
  logic              rd_fire, wr_fire, rd_valid;
  logic [ADDR_W-1:0] acc_addr, wr_addr;
  logic [LANES-1:0]  wr_lanes;

  assign selected = !sel1_n && sel2 && !sel3_n;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .selected(selected),
    .sleep(sleep), .wr_n(wr_n), .adv_ld(adv_ld), .byte_wr_n(byte_wr_n),
    .addr(addr), .interleave(burst_interleave), .rd_fire(rd_fire),
    .acc_addr(acc_addr), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_lanes(wr_lanes), .rd_valid(rd_valid)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_addr(acc_addr),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .wr_data(din), .rd_data(dout)
  );

  assign dout_en = rd_valid && !oe_n && !sleep;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cken_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              wr_n,
  input logic              adv_ld,
  input logic              oe_n,
  input logic              sleep,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic sel_ok;
  assign sel_ok = !sel1_n && sel2 && !sel3_n;

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !dout_en);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv_ld && sel_ok && wr_n && !sleep) ##1 (!oe_n && !sleep) |-> dout_en);

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cken_n |=> $stable(dout));

  assert_deselect_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv_ld && !sel_ok) |=> !dout_en);

  assert_adv_stays_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv_ld && !sel_ok) ##1 (!cken_n && adv_ld) |=> !dout_en);

  assert_write_phase_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv_ld && sel_ok && !wr_n && !sleep) |=> !dout_en);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  assert_sleep_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .wr_n(wr_n), .adv_ld(adv_ld), .oe_n(oe_n), .sleep(sleep),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam logic [35:0] A0 = 36'h111111111;
  localparam logic [35:0] A1 = 36'h222222222;
  localparam logic [35:0] A2 = 36'h333333333;
  localparam logic [35:0] A3 = 36'h1F0F0F0F0;
  localparam logic [35:0] B  = 36'hABCDEF012;
  localparam logic [35:0] X  = 36'h0;

  // Lane i at bits 9i+8..9i; an active-low enable selects the new lane value.
  function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                        input logic [3:0] be_n);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = be_n[i] ? old_w[i*9 +: 9] : new_w[i*9 +: 9];
    return r;
  endfunction

  localparam logic [35:0] M = merge(A1, B, 4'b1010);

  typedef struct packed {
    logic        cken_n;
    logic        sel_ok;
    logic        wr_n;
    logic        adv;
    logic [3:0]  be_n;
    logic [5:0]  addr;
    logic [35:0] din;
    logic        oe_n;
    logic        exp_en;
    logic [35:0] exp_dout;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 6'h10, X,  1'b0, 1'b0, X,  4'd9},  // R9 write load 0x10
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, A0, 1'b0, 1'b0, X,  4'd9},  // R9 beat, data 0x10
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, A1, 1'b0, 1'b0, X,  4'd3},  // R3 data 0x11
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, A2, 1'b0, 1'b0, X,  4'd3},  // R3 data 0x12
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 6'h00, A3, 1'b0, 1'b0, X,  4'd7},  // R7 deselect, data 0x13
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h12, X,  1'b0, 1'b1, A2, 4'd2},  // R2 read 0x12
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, X,  1'b0, 1'b1, A3, 4'd4},  // R4 0x13
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, X,  1'b0, 1'b1, A0, 4'd4},  // R4 wrap 0x10
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, X,  1'b0, 1'b1, A1, 4'd4},  // R4 0x11
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, X,  1'b0, 1'b1, A1, 4'd6},  // R6 stall holds
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, X,  1'b0, 1'b1, A2, 4'd6},  // R6 resumes at 0x12
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h10, X,  1'b1, 1'b0, X,  4'd10}, // R10 oe_n high
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'hA, 6'h11, X,  1'b0, 1'b0, X,  4'd9},  // R9 partial write
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h11, B,  1'b0, 1'b1, M,  4'd12}, // R12 forward
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h11, X,  1'b0, 1'b1, M,  4'd3},  // R3 stored lanes
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 6'h00, X,  1'b0, 1'b0, X,  4'd7},  // R7 deselect
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 6'h00, B,  1'b0, 1'b0, X,  4'd8},  // R8 advance stays off
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h13, X,  1'b0, 1'b1, A3, 4'd2}   // R2 0x13 untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cken_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic        wr_n = 1'b1, adv_ld = 1'b0, burst_interleave = 1'b0;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  byte_wr_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .wr_n(wr_n), .adv_ld(adv_ld), .byte_wr_n(byte_wr_n),
    .addr(addr), .burst_interleave(burst_interleave), .din(din), .oe_n(oe_n),
    .sleep(sleep), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic exp_en, input logic [35:0] exp_d,
                       input bit use_d);
    checks++;
    if (dout_en !== exp_en || (use_d && dout !== exp_d)) begin
      fails++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               req, dout_en, dout, exp_en, exp_d);
    end
  endtask

  task automatic step(input logic ck, input logic s1, input logic s2, input logic s3,
                      input logic w, input logic adv, input logic [3:0] be,
                      input logic [5:0] a, input logic [35:0] d, input logic oe);
    @(negedge clk);
    cken_n = ck; sel1_n = s1; sel2 = s2; sel3_n = s3; wr_n = w; adv_ld = adv;
    byte_wr_n = be; addr = a; din = d; oe_n = oe;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b0, 36'h0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].cken_n, 1'b0, VEC[i].sel_ok, 1'b0, VEC[i].wr_n, VEC[i].adv,
           VEC[i].be_n, VEC[i].addr, VEC[i].din, VEC[i].oe_n);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp_en, VEC[i].exp_dout,
            VEC[i].exp_en);
    end

    // R5 interleaved order from start 1: 1,0,3,2
    burst_interleave = 1'b1;
    step(0, 0, 1, 0, 1, 0, 4'hF, 6'h11, X, 0); check("R5 beat0", 1'b1, M,  1'b1);
    step(0, 0, 1, 0, 1, 1, 4'hF, 6'h00, X, 0); check("R5 beat1", 1'b1, A0, 1'b1);
    step(0, 0, 1, 0, 1, 1, 4'hF, 6'h00, X, 0); check("R5 beat2", 1'b1, A3, 1'b1);
    step(0, 0, 1, 0, 1, 1, 4'hF, 6'h00, X, 0); check("R5 beat3", 1'b1, A2, 1'b1);
    burst_interleave = 1'b0;

    // R10 asynchronous output enable
    step(0, 0, 1, 0, 1, 0, 4'hF, 6'h12, X, 0); check("R10 read", 1'b1, A2, 1'b1);
    oe_n = 1'b1; #0.5; check("R10 oe_n high", 1'b0, X, 1'b0);
    oe_n = 1'b0; #0.5; check("R10 oe_n low", 1'b1, A2, 1'b1);

    // R7 each wrong select combination deselects
    step(0, 1, 1, 0, 1, 0, 4'hF, 6'h12, X, 0); check("R7 sel1_n high", 1'b0, X, 1'b0);
    step(0, 0, 1, 0, 1, 0, 4'hF, 6'h12, X, 0); check("R7 reselect", 1'b1, A2, 1'b1);
    step(0, 0, 0, 0, 1, 0, 4'hF, 6'h12, X, 0); check("R7 sel2 low", 1'b0, X, 1'b0);
    step(0, 0, 1, 1, 1, 0, 4'hF, 6'h12, X, 0); check("R7 sel3_n high", 1'b0, X, 1'b0);

    // R11 sleep blocks accesses and preserves contents
    sleep = 1'b1;
    step(0, 0, 1, 0, 0, 0, 4'h0, 6'h10, X, 0);         check("R11 write ignored", 1'b0, X, 1'b0);
    step(0, 0, 1, 0, 1, 0, 4'hF, 6'h10, 36'hFFFFFFFFF, 0); check("R11 read blocked", 1'b0, X, 1'b0);
    sleep = 1'b0;
    step(0, 0, 1, 0, 1, 0, 4'hF, 6'h10, X, 0);         check("R11 preserved", 1'b1, A0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule